// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block is a 1 KB data cache with 32-byte lines. It sits between a processor port and a slower word-serial memory port. Every memory address has exactly one home line. The cache answers word reads and byte-enabled word writes from its own storage when the access hits. When an access misses, the cache stalls the processor while it brings the line in from memory. A store that misses fetches the whole line first and then merges its bytes into it. Modified lines are written to memory only when they are displaced.

The processor raises `cpu_req` and holds the address, write flag, byte enables and write data steady until `cpu_done` is high. A hit completes combinationally in the cycle the request is seen. A miss is handled by a controller with four states:
- `ST_IDLE`: looks the request up.
- `ST_EVICT`: writes back a modified victim.
- `ST_FILL`: reads the new line.
- `ST_INSTALL`: records the tag and marks the line present.

The transitions are:
- `ST_IDLE` to `ST_EVICT` on a miss whose victim is dirty.
- `ST_IDLE` to `ST_FILL` on a miss whose victim is clean or absent.
- `ST_EVICT` to `ST_FILL` after the eighth word has been written.
- `ST_FILL` to `ST_INSTALL` after the eighth word has been read.
- `ST_INSTALL` to `ST_IDLE` unconditionally.

Back in idle, the held request now hits and completes.

Top module: `dmwb_cache`

## Requirements
- R1: The byte address is decoded as tag = bits 31..10, line index = bits 9..5 (32 lines), and word within the line = bits 4..2. Bits 1..0 are ignored.
- R2: A request hits when the indexed line is present and its stored tag equals the address tag. A hit raises `cpu_done` in the same cycle, returns the stored word on `cpu_rdata`, and issues no memory transfer.
- R3: After reset no line is present, so the first access to any line is a miss.
- R4: A write hit changes only the bytes whose `cpu_be` bit is set (bit i covers data bits 8i+7..8i), marks the line modified, and performs no memory write.
- R5: A miss on a modified line first writes the victim's eight words to memory in ascending order, at address {victim tag, index, word, 00}, carrying the cached contents. All of this happens before any refill read.
- R6: A miss whose victim is absent or unmodified performs no memory write and starts the refill directly.
- R7: The refill reads eight words in ascending order at {request tag, index, word, 00}. The tag is then recorded and the line marked present, after which the pending request completes.
- R8: A write miss allocates: the line is refilled from memory and then only the enabled bytes are overwritten. The remaining bytes keep the values read from memory.
- R9: `cpu_wait` is high from the cycle a miss is detected until the cycle `cpu_done` rises. It is never high together with `cpu_done`, and both are low after reset.
- R10: `mem_req` holds with a stable address and direction until `mem_ready` is seen high at a clock edge. Each such edge transfers one word. `mem_req` is low after reset.
- R11: Two addresses with the same index but different tags displace each other, so alternating between them misses every time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address |
| cpu_be | input | 4 | Byte enables for writes |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid while `cpu_done` is high |
| cpu_wait | output | 1 | Stall indication during miss handling |
| cpu_done | output | 1 | Access completes at this clock edge |
| mem_req | output | 1 | Memory transfer requested |
| mem_we | output | 1 | 1 = write-back word, 0 = refill word |
| mem_addr | output | 32 | Word-aligned memory byte address |
| mem_wdata | output | 32 | Write-back data |
| mem_rdata | input | 32 | Refill data, sampled with `mem_ready` |
| mem_ready | input | 1 | Memory accepts or supplies the current word |

## Verification
A hit is visible as `cpu_done` in the same cycle the request is driven. The bench therefore samples one time unit after driving, at the falling edge, and classifies the access there before any clock edge has passed. A miss completes a variable number of cycles later, set by the memory model's ready spacing, plus one cycle in `ST_INSTALL` and one in `ST_IDLE`. The bench polls at each falling edge, checks `cpu_wait` at every poll until `cpu_done` appears, and only then compares the data. A write-hit update lands at the next rising edge, so it is checked by a later read rather than in the same cycle. The transfer sequence and write-back contents are logged by the memory model at the edge where each word is handed over, and are compared after the access ends.

// File: rtl/cache_pkg.sv
package cache_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EVICT,
        ST_FILL,
        ST_INSTALL
    } cache_state_t;

endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
    parameter int IDX_W = 5,
    parameter int TAG_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] line_idx,
    input  logic             install,
    input  logic [TAG_W-1:0] new_tag,
    input  logic             mark_dirty,
    output logic             line_valid,
    output logic             line_dirty,
    output logic [TAG_W-1:0] line_tag
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;
    logic [TAG_W-1:0] tag_q [LINES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            if (install) begin
                valid_q[line_idx] <= 1'b1;
                dirty_q[line_idx] <= 1'b0;
            end
            if (mark_dirty) begin
                dirty_q[line_idx] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (install) begin
            tag_q[line_idx] <= new_tag;
        end
    end

    assign line_valid = valid_q[line_idx];
    assign line_dirty = dirty_q[line_idx];
    assign line_tag   = tag_q[line_idx];

endmodule

// File: rtl/cache_data_store.sv
module cache_data_store #(
    parameter int AW     = 8,
    parameter int WORD_W = 32
) (
    input  logic                  clk,
    input  logic                  wr_en,
    input  logic [AW-1:0]         wr_addr,
    input  logic [WORD_W/8-1:0]   wr_be,
    input  logic [WORD_W-1:0]     wr_data,
    input  logic [AW-1:0]         rd_addr,
    output logic [WORD_W-1:0]     rd_data
);
    localparam int DEPTH = 1 << AW;
    localparam int NB    = WORD_W / 8;

    logic [WORD_W-1:0] words_q [DEPTH];

    always_ff @(posedge clk) begin
        for (int b = 0; b < NB; b++) begin
            if (wr_en && wr_be[b]) begin
                words_q[wr_addr][8*b +: 8] <= wr_data[8*b +: 8];
            end
        end
    end

    assign rd_data = words_q[rd_addr];

endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
    import cache_pkg::*;
#(
    parameter int WSEL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              hit,
    input  logic              victim_dirty,
    input  logic              mem_ready,
    output logic              cpu_wait,
    output logic              cpu_done,
    output logic              mem_req,
    output logic              mem_we,
    output logic              fill_we,
    output logic              install,
    output logic              evicting,
    output logic [WSEL_W-1:0] word_cnt
);
    cache_state_t state_q, state_d;
    logic [WSEL_W-1:0] cnt_q;
    logic              last_word;
    logic              step;

    assign last_word = &cnt_q;
    assign word_cnt  = cnt_q;
    assign step      = mem_ready && (state_q == ST_EVICT || state_q == ST_FILL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) begin
                cnt_q <= '0;
            end else if (step) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        state_d  = state_q;
        cpu_wait = 1'b0;
        cpu_done = 1'b0;
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        fill_we  = 1'b0;
        install  = 1'b0;
        evicting = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (hit) begin
                        cpu_done = 1'b1;
                    end else begin
                        cpu_wait = 1'b1;
                        state_d  = victim_dirty ? ST_EVICT : ST_FILL;
                    end
                end
            end
            ST_EVICT: begin
                cpu_wait = 1'b1;
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                evicting = 1'b1;
                if (mem_ready && last_word) begin
                    state_d = ST_FILL;
                end
            end
            ST_FILL: begin
                cpu_wait = 1'b1;
                mem_req  = 1'b1;
                fill_we  = mem_ready;
                if (mem_ready && last_word) begin
                    state_d = ST_INSTALL;
                end
            end
            ST_INSTALL: begin
                cpu_wait = 1'b1;
                install  = 1'b1;
                state_d  = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/dmwb_cache.sv
module dmwb_cache
    import cache_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 5,
    parameter int OFF_W  = 5,
    parameter int WORD_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cpu_req,
    input  logic                  cpu_we,
    input  logic [ADDR_W-1:0]     cpu_addr,
    input  logic [WORD_W/8-1:0]   cpu_be,
    input  logic [WORD_W-1:0]     cpu_wdata,
    output logic [WORD_W-1:0]     cpu_rdata,
    output logic                  cpu_wait,
    output logic                  cpu_done,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [WORD_W-1:0]     mem_wdata,
    input  logic [WORD_W-1:0]     mem_rdata,
    input  logic                  mem_ready
);
    localparam int NB     = WORD_W / 8;
    localparam int BYTE_W = $clog2(NB);
    localparam int WSEL_W = OFF_W - BYTE_W;
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int DAW    = IDX_W + WSEL_W;

    logic [TAG_W-1:0]  req_tag;
    logic [IDX_W-1:0]  req_idx;
    logic [WSEL_W-1:0] req_word;
    logic [BYTE_W-1:0] unused_byte_off;

    assign req_tag         = cpu_addr[ADDR_W-1 -: TAG_W];
    assign req_idx         = cpu_addr[OFF_W +: IDX_W];
    assign req_word        = cpu_addr[BYTE_W +: WSEL_W];
    assign unused_byte_off = cpu_addr[BYTE_W-1:0];

    logic              line_valid, line_dirty;
    logic [TAG_W-1:0]  line_tag;
    logic              hit;
    logic              fill_we, install, evicting;
    logic [WSEL_W-1:0] word_cnt;
    logic              mark_dirty;

    assign hit        = line_valid && (line_tag == req_tag);
    assign mark_dirty = cpu_done && cpu_we;

    cache_ctrl #(.WSEL_W(WSEL_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_req      (cpu_req),
        .hit          (hit),
        .victim_dirty (line_valid && line_dirty),
        .mem_ready    (mem_ready),
        .cpu_wait     (cpu_wait),
        .cpu_done     (cpu_done),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .fill_we      (fill_we),
        .install      (install),
        .evicting     (evicting),
        .word_cnt     (word_cnt)
    );

    cache_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_idx   (req_idx),
        .install    (install),
        .new_tag    (req_tag),
        .mark_dirty (mark_dirty),
        .line_valid (line_valid),
        .line_dirty (line_dirty),
        .line_tag   (line_tag)
    );

    logic              dwr_en;
    logic [DAW-1:0]    dwr_addr, drd_addr;
    logic [NB-1:0]     dwr_be;
    logic [WORD_W-1:0] dwr_data, drd_data;

    always_comb begin
        if (fill_we) begin
            dwr_en   = 1'b1;
            dwr_addr = {req_idx, word_cnt};
            dwr_be   = '1;
            dwr_data = mem_rdata;
        end else begin
            dwr_en   = mark_dirty;
            dwr_addr = {req_idx, req_word};
            dwr_be   = cpu_be;
            dwr_data = cpu_wdata;
        end
        drd_addr = evicting ? {req_idx, word_cnt} : {req_idx, req_word};
    end

    cache_data_store #(.AW(DAW), .WORD_W(WORD_W)) u_data (
        .clk     (clk),
        .wr_en   (dwr_en),
        .wr_addr (dwr_addr),
        .wr_be   (dwr_be),
        .wr_data (dwr_data),
        .rd_addr (drd_addr),
        .rd_data (drd_data)
    );

    assign mem_addr  = {(evicting ? line_tag : req_tag), req_idx, word_cnt, {BYTE_W{1'b0}}};
    assign mem_wdata = drd_data;
    assign cpu_rdata = drd_data;

endmodule

// File: rtl/cache_checker.sv
module cache_checker #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic              cpu_done,
    input logic              cpu_wait,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr
);
    localparam int WS = OFF_W - 2;

    logic [WS-1:0] word_q;
    logic          word_last;

    assign word_q    = mem_addr[OFF_W-1:2];
    assign word_last = (word_q == {WS{1'b1}});

    AST_DONE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |-> cpu_req); // R2

    AST_NO_MEM_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |-> !mem_req); // R2

    AST_DONE_NOT_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |-> !cpu_wait); // R9

    AST_STALL_DURING_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> cpu_wait); // R9

    AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R10

    AST_WORD_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && !word_last) |=>
            (mem_req && word_q == $past(word_q) + 1'b1)); // R7

    AST_WB_THEN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ready && word_last) |=> (mem_req && !mem_we)); // R5

endmodule

bind dmwb_cache cache_checker u_cache_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_done  (cpu_done),
    .cpu_wait  (cpu_wait),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr)
);

// File: tb/test_dmwb_cache.sv
`timescale 1ns/1ps
module test_dmwb_cache;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [3:0]  cpu_be = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_wait, cpu_done;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;

    always #4 clk = ~clk;

    dmwb_cache i_dmwb_cache (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_be(cpu_be), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_wait(cpu_wait), .cpu_done(cpu_done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [31:0] mem_model [2048];
    logic [31:0] ref_mem   [2048];
    logic        ref_valid [32];
    logic        ref_dirty [32];
    int          ref_tag   [32];
    logic [31:0] log_addr  [32];
    logic        log_we    [32];
    int          log_n = 0;
    int          lat = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory model: one word every third cycle, driven at the falling edge
    always @(negedge clk) begin
        if (mem_ready) begin
            mem_ready = 1'b0;
        end else if (rst_n && mem_req) begin
            if (lat == 1) begin
                lat = 0;
                mem_ready = 1'b1;
                if (log_n < 32) begin
                    log_addr[log_n] = mem_addr;
                    log_we[log_n]   = mem_we;
                end
                log_n++;
                if (mem_we) mem_model[mem_addr[12:2]] = mem_wdata;
                else        mem_rdata = mem_model[mem_addr[12:2]];
            end else begin
                lat++;
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic access(input bit we, input int tag, input int idx, input int word,
                          input logic [3:0] be, input logic [31:0] wd);
        logic [31:0] a;
        int          mi, nwb, nrd, n, old_tag;
        bit          exp_hit, exp_wb, got_hit, wait_ok, seq_ok;
        logic [31:0] exp_a, got;
        string       hm_req;
        a = {22'(tag), 5'(idx), 3'(word), 2'b00};
        mi = int'(a[12:2]);
        exp_hit = ref_valid[idx] && ref_tag[idx] == tag;
        exp_wb  = !exp_hit && ref_valid[idx] && ref_dirty[idx];
        old_tag = ref_tag[idx];
        hm_req  = exp_hit ? "R2" : (ref_valid[idx] ? "R11" : "R3");
        log_n = 0;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_be = be; cpu_wdata = wd;
        #1;
        got_hit = cpu_done;
        chk(got_hit == exp_hit, hm_req, 32'(got_hit), 32'(exp_hit));
        wait_ok = 1'b1;
        n = 0;
        if (!cpu_done) begin
            if (!cpu_wait) wait_ok = 1'b0;
            while (!cpu_done && n < 400) begin
                @(negedge clk); #1;
                if (!cpu_done && !cpu_wait) wait_ok = 1'b0;
                if (cpu_done && cpu_wait) wait_ok = 1'b0;
                n++;
            end
            chk(n < 400, "R7 completion", 32'(n), 32'd400);
            chk(wait_ok, "R9 wait", 32'(wait_ok), 32'd1);
        end
        got = cpu_rdata;
        nwb = exp_wb ? 8 : 0;
        nrd = exp_hit ? 0 : 8;
        chk(log_n == nwb + nrd, exp_wb ? "R5 transfers" : (exp_hit ? "R2 no transfers" : "R6 transfers"),
            32'(log_n), 32'(nwb + nrd));
        seq_ok = 1'b1;
        for (int k = 0; k < nwb + nrd && k < log_n; k++) begin
            if (k < nwb) exp_a = {22'(old_tag), 5'(idx), 3'(k), 2'b00};
            else         exp_a = {22'(tag), 5'(idx), 3'(k - nwb), 2'b00};
            if (log_addr[k] != exp_a || log_we[k] != (k < nwb)) seq_ok = 1'b0;
        end
        if (!exp_hit) chk(seq_ok, "R1/R5/R7 order", 32'(seq_ok), 32'd1);
        if (exp_wb) begin
            for (int k = 0; k < 8; k++) begin
                exp_a = {22'(old_tag), 5'(idx), 3'(k), 2'b00};
                chk(mem_model[exp_a[12:2]] == ref_mem[exp_a[12:2]], "R5 data",
                    mem_model[exp_a[12:2]], ref_mem[exp_a[12:2]]);
            end
        end
        if (!we) begin
            chk(got == ref_mem[mi], exp_hit ? "R2 rdata" : "R7 rdata", got, ref_mem[mi]);
        end else begin
            for (int b = 0; b < 4; b++)
                if (be[b]) ref_mem[mi][8*b +: 8] = wd[8*b +: 8];
        end
        ref_dirty[idx] = exp_hit ? (ref_dirty[idx] | we) : we;
        ref_valid[idx] = 1'b1;
        ref_tag[idx]   = tag;
        @(posedge clk);
        @(negedge clk);
        cpu_req = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 2048; i++) begin
            mem_model[i] = (32'(i) * 32'h0100_0193) ^ 32'hC3A5_0000;
            ref_mem[i]   = mem_model[i];
        end
        for (int i = 0; i < 32; i++) begin
            ref_valid[i] = 1'b0; ref_dirty[i] = 1'b0; ref_tag[i] = 0;
        end
        repeat (3) @(negedge clk);
        chk(!cpu_wait && !cpu_done, "R9 reset", {30'd0, cpu_wait, cpu_done}, 32'd0);
        chk(!mem_req, "R10 reset", 32'(mem_req), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: cold misses on every line
        for (int i = 0; i < 32; i++) access(1'b0, 0, i, i % 8, 4'h0, 32'h0);
        // R2: hits on other words of the same lines
        for (int i = 0; i < 32; i++) access(1'b0, 0, i, (i + 5) % 8, 4'h0, 32'h0);
        // R4: byte-enabled write hits, all 16 enable patterns
        for (int i = 0; i < 32; i++)
            access(1'b1, 0, i, (i + 3) % 8, 4'(i % 16), 32'hA5000000 | (32'(i) * 32'h0001_0101));
        for (int i = 0; i < 32; i++) access(1'b0, 0, i, (i + 3) % 8, 4'h0, 32'h0);
        // R5 / R11: conflicting tag evicts dirty lines
        for (int i = 0; i < 32; i++) access(1'b0, 1, i, i % 8, 4'h0, 32'h0);
        // R6 / R11: back to the first tag, victim clean; written data came back from memory
        for (int i = 0; i < 8; i++) access(1'b0, 0, i, (i + 3) % 8, 4'h0, 32'h0);
        // R8: write miss allocates and merges
        for (int i = 8; i < 16; i++) begin
            access(1'b1, 2, i, 1, 4'(i + 1), 32'h1234_5678 + 32'(i));
            access(1'b0, 2, i, 1, 4'h0, 32'h0);
            access(1'b0, 2, i, 6, 4'h0, 32'h0);
        end
        // R5: write-allocated lines are dirty and get written back
        for (int i = 8; i < 12; i++) access(1'b0, 3, i, 0, 4'h0, 32'h0);
        for (int i = 8; i < 12; i++) access(1'b0, 2, i, 1, 4'h0, 32'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule